// File: doc/BRIEF.md
# Dual-Oscillator Clock Source and Stop Recovery Controller

This block supervises the two clock sources of a small microcontroller: a fast main oscillator that software or a STOP request can halt, and a slow sub-oscillator that is never halted. It produces the main-oscillator enable and the control for the system clock multiplexer. It refuses any switch onto a source whose ready flag is low. The sub-oscillator ready flag comes from outside. The main ready flag is made inside the block by a start-up timer.

The start-up timer is a 6-bit counter that counts carry pulses from a 7-bit prescaler. The prescaler advances on every cycle in which the main oscillator is enabled. Only power-on reset clears it. The counter is cleared whenever the main oscillator is off. After the oscillator restarts, the delay before the counter overflows therefore depends on whatever value the prescaler was left holding. While the main oscillator is the system clock, internal reset is held through this delay after a wake-up or an external reset.

Top module: `osc_stop_ctrl`

## Requirements
- R1: While `rst_n` is low and just after it rises, and in the cycle after an `ext_rst` pulse, the block shows its defaults: `clk_sel`=0 (select code 00), `main_osc_en`=1, `int_rst`=1, `low_pwr`=0, `sel_err`=0.
- R2: `main_osc_en` equals the enable bit ANDed with not-stopped. A configuration write with `cfg_men`=0 drives `main_osc_en` and `main_rdy` low in the next cycle. A write with `cfg_men`=1 turns the oscillator back on without asserting `int_rst`.
- R3: The select field is encoded as follows: code 2'b11 selects the sub-oscillator (`clk_sel`=1), and codes 2'b00, 2'b01 and 2'b10 all select the main oscillator (`clk_sel`=0).
- R4: A write of code 11 while `sub_rdy` is low is rejected. The previous selection stays and the sticky `sel_err` goes high. Only `rst_n` or `ext_rst` clears `sel_err`.
- R5: A write that moves the selection from the sub-oscillator to a main code while `main_rdy` is low is rejected, and the previous selection stays. The same write is accepted once `main_rdy` is high.
- R6: A `stop_req` pulse taken while `int_rst` is low sets `low_pwr` and clears `main_osc_en` and `main_rdy` in the next cycle. A `stop_req` taken while `int_rst` is high is ignored.
- R7: With the main oscillator selected, a wake by `ext_irq` holds `int_rst` high for exactly 8192−p clock edges, where p is the prescaler value at wake-up. p equals the number of edges with `main_osc_en` high since `rst_n` rose, taken modulo 128. The hold therefore lies between 8065 and 8192 edges.
- R8: A wake by `ext_irq` leaves the selection and the enable bit as they were before STOP.
- R9: STOP taken while code 11 is selected keeps `clk_sel`=1 and never asserts `int_rst`. After the wake, `main_rdy` rises 8192−p edges after the wake edge.
- R10: `ext_rst` ends STOP and restores the R1 defaults. It does not clear the prescaler, so the following `int_rst` hold lasts 8192−p edges.
- R11: Configuration writes are ignored while `low_pwr` or `int_rst` is high.
- R12: After `rst_n` rises, `int_rst` stays high for exactly 8192 edges, and `main_rdy` is high when it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one edge per main-oscillator cycle |
| rst_n | input | 1 | Asynchronous power-on reset, active low; clears the prescaler |
| ext_rst | input | 1 | Synchronous external reset pulse; wakes from STOP |
| stop_req | input | 1 | STOP request pulse |
| ext_irq | input | 1 | External interrupt; wakes from STOP |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Requested clock select code |
| cfg_men | input | 1 | Requested main-oscillator enable bit |
| sub_rdy | input | 1 | Sub-oscillator ready flag |
| main_osc_en | output | 1 | Main-oscillator run enable |
| clk_sel | output | 1 | System clock mux control, 1 = sub-oscillator |
| int_rst | output | 1 | Internal reset to the core |
| low_pwr | output | 1 | Low-power (STOP) status |
| main_rdy | output | 1 | Main-oscillator ready flag |
| sel_err | output | 1 | Sticky rejected-switch flag |

## Verification
The hardest condition to reach is a wake-up with a known, nonzero prescaler residue. The residue is never visible at the ports, and it decides the exact length of the reset hold. The bench rebuilds it by counting every edge on which `main_osc_en` is high since power-on. It inserts idle stretches of 37 and 50 cycles between STOP episodes so that each wake starts from a different residue. A driver pushes the expected hold length of each episode into a queue, and a monitor measures the episode and pops the expected length when `int_rst` falls.

// File: rtl/osc_stop_pkg.sv
package osc_stop_pkg;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_SUB  = 2'b11;
    localparam logic [SEL_W-1:0] SEL_BOOT = 2'b00;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             men;
        logic             stop;
        logic             hold;
        logic             rdy;
        logic             err;
    } ctl_t;

endpackage

// File: rtl/osc_startup_timer.sv
module osc_startup_timer #(
    parameter int PRE_W = 7,
    parameter int CNT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic arm,
    input  logic clr,
    output logic ovf
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        ovf   = 1'b0;
        if (run) begin
            tmr_d.pre = tmr_q.pre + 1'b1;
        end
        if (clr) begin
            tmr_d.cnt = '0;
        end else if (run && arm && (&tmr_q.pre)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
            ovf       = &tmr_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R7: the counter only steps up on a prescaler wrap
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.cnt != $past(tmr_q.cnt)) && (tmr_q.cnt != '0) |-> $past(&tmr_q.pre));

    // R10: the prescaler never moves while the oscillator is off
    pre_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (tmr_q.pre == $past(tmr_q.pre)));

endmodule

// File: rtl/osc_sel_gate.sv
module osc_sel_gate
    import osc_stop_pkg::*;
(
    input  logic             wr,
    input  logic [SEL_W-1:0] sel_new,
    input  logic [SEL_W-1:0] sel_cur,
    input  logic             sub_ok,
    input  logic             main_ok,
    output logic             accept,
    output logic             reject
);

    logic to_sub;
    logic from_sub;
    logic allowed;

    always_comb begin
        to_sub   = (sel_new == SEL_SUB);
        from_sub = (sel_cur == SEL_SUB);
        if (to_sub) begin
            allowed = sub_ok;
        end else if (from_sub) begin
            allowed = main_ok;
        end else begin
            allowed = 1'b1;
        end
        accept = wr & allowed;
        reject = wr & ~allowed;
    end

endmodule

// File: rtl/osc_stop_ctrl.sv
module osc_stop_ctrl
    import osc_stop_pkg::*;
#(
    parameter int PRE_W = 7,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst,
    input  logic             stop_req,
    input  logic             ext_irq,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_men,
    input  logic             sub_rdy,
    output logic             main_osc_en,
    output logic             clk_sel,
    output logic             int_rst,
    output logic             low_pwr,
    output logic             main_rdy,
    output logic             sel_err
);

    ctl_t ctl_d, ctl_q;
    logic run;
    logic cnt_clr;
    logic ovf;
    logic sel_acc;
    logic sel_rej;
    logic wr_ok;

    assign run   = ctl_q.men & ~ctl_q.stop;
    assign wr_ok = cfg_wr & ~ctl_q.hold & ~ctl_q.stop & ~ext_rst;

    osc_sel_gate i_gate (
        .wr      (wr_ok),
        .sel_new (cfg_sel),
        .sel_cur (ctl_q.sel),
        .sub_ok  (sub_rdy),
        .main_ok (ctl_q.rdy),
        .accept  (sel_acc),
        .reject  (sel_rej)
    );

    osc_startup_timer #(
        .PRE_W (PRE_W),
        .CNT_W (CNT_W)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .arm   (~ctl_q.rdy),
        .clr   (cnt_clr),
        .ovf   (ovf)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ext_rst) begin
            ctl_d.sel  = SEL_BOOT;
            ctl_d.men  = 1'b1;
            ctl_d.stop = 1'b0;
            ctl_d.hold = 1'b1;
            ctl_d.rdy  = 1'b0;
            ctl_d.err  = 1'b0;
        end else if (ctl_q.stop) begin
            if (ext_irq) begin
                ctl_d.stop = 1'b0;
                ctl_d.hold = (ctl_q.sel != SEL_SUB);
            end
        end else if (stop_req && !ctl_q.hold) begin
            ctl_d.stop = 1'b1;
            ctl_d.rdy  = 1'b0;
        end else begin
            if (ovf) begin
                ctl_d.rdy  = 1'b1;
                ctl_d.hold = 1'b0;
            end
            if (wr_ok) begin
                ctl_d.men = cfg_men;
                if (!cfg_men) begin
                    ctl_d.rdy = 1'b0;
                end
                if (sel_acc) begin
                    ctl_d.sel = cfg_sel;
                end
                if (sel_rej) begin
                    ctl_d.err = 1'b1;
                end
            end
        end
        cnt_clr = ext_rst | ~(ctl_d.men & ~ctl_d.stop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{sel: SEL_BOOT, men: 1'b1, stop: 1'b0, hold: 1'b1, rdy: 1'b0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign main_osc_en = run;
    assign clk_sel     = (ctl_q.sel == SEL_SUB);
    assign int_rst     = ctl_q.hold;
    assign low_pwr     = ctl_q.stop;
    assign main_rdy    = ctl_q.rdy;
    assign sel_err     = ctl_q.err;

    // R4
    sub_switch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel) |-> $past(sub_rdy));

    // R5
    main_switch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_sel) |-> ($past(main_rdy) || $past(ext_rst)));

    // R6
    stop_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_pwr |-> (!main_osc_en && !main_rdy));

    // R7
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_rst) |-> main_rdy);

    // R9
    sub_stop_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(low_pwr) && $past(clk_sel) && !$past(ext_rst)) |-> !int_rst);

    // R11
    frozen_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_pwr && $past(low_pwr)) |-> $stable(clk_sel));

endmodule

// File: tb/test_osc_stop_ctrl.sv
`timescale 1ns/1ps
module test_osc_stop_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ext_rst, stop_req, ext_irq, cfg_wr, cfg_men, sub_rdy;
    logic [1:0] cfg_sel;
    logic       main_osc_en, clk_sel, int_rst, low_pwr, main_rdy, sel_err;

    int nchk = 0;
    int nerr = 0;
    int runcnt = 0;
    int hcnt = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    osc_stop_ctrl i_osc_stop_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .stop_req(stop_req),
        .ext_irq(ext_irq), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_men(cfg_men),
        .sub_rdy(sub_rdy), .main_osc_en(main_osc_en), .clk_sel(clk_sel),
        .int_rst(int_rst), .low_pwr(low_pwr), .main_rdy(main_rdy), .sel_err(sel_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic m);
        cfg_sel = s;
        cfg_men = m;
        cfg_wr  = 1'b1;
        tick();
        cfg_wr  = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
    endtask

    // model of the prescaler residue: enabled edges since power-on
    always @(posedge clk) begin
        if (!rst_n) runcnt = 0;
        else if (main_osc_en) runcnt = runcnt + 1;
    end

    // monitor: measure each internal reset episode, compare with the queue
    always @(posedge clk) begin
        if (!rst_n) begin
            hcnt = 0;
        end else if (int_rst) begin
            hcnt = hcnt + 1;
        end else if (hcnt != 0) begin
            if (exp_q.size() == 0) chk("R7 unexpected hold episode", hcnt, 0);
            else chk("R7/R10/R12 hold length", hcnt, exp_q.pop_front());
            hcnt = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int p;
        int n;
        rst_n = 1'b0; ext_rst = 1'b0; stop_req = 1'b0; ext_irq = 1'b0;
        cfg_wr = 1'b0; cfg_men = 1'b1; cfg_sel = 2'b00; sub_rdy = 1'b0;
        repeat (3) @(negedge clk);
        // R1 defaults during reset
        chk("R1 int_rst", int_rst, 1);
        chk("R1 osc_en", main_osc_en, 1);
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 low_pwr", low_pwr, 0);
        chk("R1 sel_err", sel_err, 0);
        exp_q.push_back(8192); // R12
        rst_n = 1'b1;

        // R11: writes ignored during the power-on hold
        sub_rdy = 1'b1;
        wr(2'b11, 1'b1);
        chk("R11 write in hold", clk_sel, 0);
        while (int_rst) tick();
        chk("R12 main_rdy at release", main_rdy, 1);

        // R3: select encodings
        wr(2'b01, 1'b1); chk("R3 code 01", clk_sel, 0);
        wr(2'b10, 1'b1); chk("R3 code 10", clk_sel, 0);
        wr(2'b00, 1'b1); chk("R3 code 00", clk_sel, 0);
        // R4: switch to sub refused without its ready flag
        sub_rdy = 1'b0;
        wr(2'b11, 1'b1);
        chk("R4 kept main", clk_sel, 0);
        chk("R4 err set", sel_err, 1);
        sub_rdy = 1'b1;
        wr(2'b11, 1'b1);
        chk("R3 code 11", clk_sel, 1);
        chk("R4 err sticky", sel_err, 1);

        repeat (37) tick();

        // R9: STOP while on the sub-oscillator
        pulse_stop();
        chk("R6 low_pwr", low_pwr, 1);
        chk("R6 osc off", main_osc_en, 0);
        chk("R6 rdy low", main_rdy, 0);
        chk("R9 stays on sub", clk_sel, 1);
        chk("R9 no reset", int_rst, 0);
        wr(2'b00, 1'b0);
        chk("R11 write in stop sel", clk_sel, 1);
        chk("R11 write in stop en", main_osc_en, 0);
        ext_irq = 1'b1;
        tick();
        ext_irq = 1'b0;
        chk("R8 wake", low_pwr, 0);
        chk("R8 enable kept", main_osc_en, 1);
        chk("R9 no reset after wake", int_rst, 0);
        p = runcnt % 128;
        n = 0;
        cfg_sel = 2'b00; cfg_men = 1'b1; cfg_wr = 1'b1;
        @(posedge clk); n++;
        @(negedge clk); cfg_wr = 1'b0;
        chk("R5 switch to main refused", clk_sel, 1);
        while (!main_rdy) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        chk("R9 main_rdy delay", n, 8192 - p);
        chk("R9 reset never seen", int_rst, 0);
        wr(2'b00, 1'b1);
        chk("R5 switch to main accepted", clk_sel, 0);

        repeat (50) tick();

        // R7/R8: STOP with the main oscillator selected
        wr(2'b10, 1'b1);
        pulse_stop();
        chk("R6 low_pwr main", low_pwr, 1);
        ext_irq = 1'b1;
        tick();
        ext_irq = 1'b0;
        exp_q.push_back(8192 - (runcnt % 128)); // R7
        chk("R7 reset held", int_rst, 1);
        wr(2'b11, 1'b1);
        chk("R11 write during wake hold", clk_sel, 0);
        while (int_rst) tick();
        chk("R8 sel kept", clk_sel, 0);
        chk("R8 osc on", main_osc_en, 1);

        // R2: enable bit
        wr(2'b00, 1'b0);
        chk("R2 osc off", main_osc_en, 0);
        chk("R2 rdy off", main_rdy, 0);
        wr(2'b00, 1'b1);
        chk("R2 osc on", main_osc_en, 1);
        chk("R2 no reset", int_rst, 0);

        // R10: external reset ends STOP
        pulse_stop();
        chk("R6 stop again", low_pwr, 1);
        ext_rst = 1'b1;
        tick();
        ext_rst = 1'b0;
        exp_q.push_back(8192 - (runcnt % 128)); // R10
        chk("R10 awake", low_pwr, 0);
        chk("R10 reset", int_rst, 1);
        chk("R10 osc on", main_osc_en, 1);
        chk("R10 sel default", clk_sel, 0);
        chk("R10 err cleared", sel_err, 0);
        pulse_stop();
        chk("R6 stop ignored in hold", low_pwr, 0);
        while (int_rst) tick();
        tick();
        chk("R7 all episodes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule